// File: doc/BRIEF.md
# Emulated Configuration-Memory Command Handshake

This block replaces a serial configuration memory inside a fieldbus slave controller. No storage is held on chip. When the bus master issues a memory command, the block captures the command code, the memory address and, for writes, the data word. It then raises a busy flag and an interrupt to a host microcontroller. The host reads the captured fields through a small register port, carries out the access in its own non-volatile memory and acknowledges the command. For a read, the host loads the result into the data register before it acknowledges.

The host acknowledges by writing the exact command code it executed back into the command field of the control word, together with two error bits. Only a matching code releases busy and the interrupt. After an acknowledged read, the data word goes back to the master side on a one-cycle valid strobe. A command that arrives while busy is set is refused, and a sticky command-error bit records the refusal.

Top module: `eeprom_emu_handshake`

## Requirements
- R1: After reset, busy, the interrupt, the command-error bit, the error bits and the read-valid strobe are all 0.
- R2: A master command with a non-zero code, issued while idle, sets busy (bit 15 of host word 0) and the interrupt in the next cycle. Both stay set until the command is acknowledged.
- R3: While busy, host word 0 bits [2:0] return the pending command code and host word 1 returns the captured address, zero-extended.
- R4: A write command (code 2) captures the master write data into host word 2 as it is issued. Every other code leaves word 2 unchanged.
- R5: A host write to word 2 replaces the data word.
- R6: A host write to word 0 whose bits [2:0] equal the pending code clears busy and the interrupt in the next cycle. It also latches bits [13:12] as the error bits, which appear on word 0 bits [13:12] and on the master-side error output.
- R7: A host write to word 0 whose bits [2:0] differ from the pending code leaves busy, the interrupt and the error bits unchanged.
- R8: A non-zero master command issued while busy is refused. Command-error (word 0 bit 14) is set, and the pending code, address and data are unchanged.
- R9: A host write to word 0 with bit 14 set clears command-error, whether or not the code matches.
- R10: Acknowledging a read command (code 1) raises the read-valid strobe for exactly one cycle, in the cycle after the acknowledge, with the data output equal to word 2. Other codes give no strobe.
- R11: A master command with code 0 has no effect, whether the block is idle or busy.
- R12: A host write to word 0 while idle leaves busy and the interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd_valid | input | 1 | Master issues a command this cycle |
| m_cmd | input | 3 | Command code (1 read, 2 write, 0 none) |
| m_addr | input | AW | Memory address of the command |
| m_wdata | input | 16 | Write data for a write command |
| m_busy | output | 1 | A command is pending |
| m_cmd_err | output | 1 | Sticky: a command was refused while busy |
| m_ack_err | output | 2 | Error bits from the last acknowledge |
| m_rdata_valid | output | 1 | One-cycle strobe after an acknowledged read |
| m_rdata | output | 16 | Data word returned to the master |
| h_wr | input | 1 | Host register write strobe |
| h_addr | input | 2 | Host word select (0 control, 1 address, 2 data) |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for the selected word |
| irq | output | 1 | Interrupt to the host |

## Verification
The hardest state to reach is a pending command that sees its own refusal and a run of wrong acknowledges before the right one. In that state, command-error must latch while the captured fields stay frozen, and busy must survive every non-matching code. For every code and several addresses, the bench first issues a command. It then sends a second command with different fields, clears the error with a mismatched control write, and tries all seven wrong codes. Only then does it acknowledge with the right code and a varying error pair.

// File: rtl/eeh_pkg.sv
package eeh_pkg;
    localparam int HW       = 16;
    localparam int CMD_W    = 3;
    localparam int BUSY_BIT = 15;
    localparam int CERR_BIT = 14;
    localparam int ERR_LO   = 12;

    localparam logic [CMD_W-1:0] CMD_NONE  = 3'd0;
    localparam logic [CMD_W-1:0] CMD_READ  = 3'd1;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'd2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_ADDR = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/eeh_hostdec.sv
module eeh_hostdec
    import eeh_pkg::*;
(
    input  logic             h_wr,
    input  logic [1:0]       h_addr,
    input  logic [CMD_W-1:0] cmd_field,
    input  logic             cerr_field,
    input  logic [1:0]       err_field,
    input  logic             busy_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             ack_o,
    output logic [1:0]       ack_err_o,
    output logic             clr_cerr_o,
    output logic             wr_data_o
);
    reg_sel_e sel;

    always_comb begin
        sel        = reg_sel_e'(h_addr);
        ack_o      = h_wr && (sel == REG_CTRL) && busy_i && (cmd_field == cmd_i);
        ack_err_o  = err_field;
        clr_cerr_o = h_wr && (sel == REG_CTRL) && cerr_field;
        wr_data_o  = h_wr && (sel == REG_DATA);
    end
endmodule

// File: rtl/eeh_core.sv
module eeh_core
    import eeh_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_cmd_valid,
    input  logic [CMD_W-1:0] m_cmd,
    input  logic [AW-1:0]    m_addr,
    input  logic [HW-1:0]    m_wdata,
    input  logic             ack_i,
    input  logic [1:0]       ack_err_i,
    input  logic             clr_cerr_i,
    input  logic             wr_data_i,
    input  logic [HW-1:0]    h_wdata_i,
    output logic             busy_o,
    output logic             cerr_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [AW-1:0]    addr_o,
    output logic [HW-1:0]    data_o,
    output logic [1:0]       err_o,
    output logic             rdv_o
);
    typedef struct packed {
        logic             busy;
        logic             cerr;
        logic [CMD_W-1:0] cmd;
        logic [AW-1:0]    addr;
        logic [HW-1:0]    data;
        logic [1:0]       err;
        logic             rdv;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdv = 1'b0;
        if (clr_cerr_i)
            st_d.cerr = 1'b0;
        if (wr_data_i)
            st_d.data = h_wdata_i;
        if (m_cmd_valid && (m_cmd != CMD_NONE)) begin
            if (st_q.busy) begin
                st_d.cerr = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.cmd  = m_cmd;
                st_d.addr = m_addr;
                if (m_cmd == CMD_WRITE)
                    st_d.data = m_wdata;
            end
        end
        if (ack_i) begin
            st_d.busy = 1'b0;
            st_d.err  = ack_err_i;
            st_d.rdv  = (st_q.cmd == CMD_READ);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign cerr_o = st_q.cerr;
    assign cmd_o  = st_q.cmd;
    assign addr_o = st_q.addr;
    assign data_o = st_q.data;
    assign err_o  = st_q.err;
    assign rdv_o  = st_q.rdv;

    // R2: busy only rises after a non-zero master command
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ($past(m_cmd_valid) && ($past(m_cmd) != CMD_NONE)));

    // R6: busy only falls after a matching acknowledge from the decoder
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(ack_i));

    // R7: without an acknowledge, a pending command stays pending
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !ack_i) |=> st_q.busy);

    // R8: a command while busy latches the error and keeps the address
    a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && m_cmd_valid && (m_cmd != CMD_NONE))
            |=> (st_q.cerr && (st_q.addr == $past(st_q.addr))));

    // R10: the strobe only follows an acknowledged read
    a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdv |-> (!st_q.busy && $past(ack_i) && ($past(st_q.cmd) == CMD_READ)));
endmodule

// File: rtl/eeh_rdmux.sv
module eeh_rdmux
    import eeh_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [1:0]       h_addr,
    input  logic             busy_i,
    input  logic             cerr_i,
    input  logic [1:0]       err_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [HW-1:0]    data_i,
    output logic [HW-1:0]    h_rdata
);
    logic [HW-1:0] ctrl_word;
    logic [HW-1:0] addr_word;

    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[BUSY_BIT]          = busy_i;
        ctrl_word[CERR_BIT]          = cerr_i;
        ctrl_word[ERR_LO+1:ERR_LO]   = err_i;
        ctrl_word[CMD_W-1:0]         = cmd_i;
        addr_word                    = '0;
        addr_word[AW-1:0]            = addr_i;
        case (reg_sel_e'(h_addr))
            REG_CTRL: h_rdata = ctrl_word;
            REG_ADDR: h_rdata = addr_word;
            REG_DATA: h_rdata = data_i;
            default:  h_rdata = '0;
        endcase
    end
endmodule

// File: rtl/eeprom_emu_handshake.sv
module eeprom_emu_handshake
    import eeh_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_cmd_valid,
    input  logic [CMD_W-1:0] m_cmd,
    input  logic [AW-1:0]    m_addr,
    input  logic [HW-1:0]    m_wdata,
    output logic             m_busy,
    output logic             m_cmd_err,
    output logic [1:0]       m_ack_err,
    output logic             m_rdata_valid,
    output logic [HW-1:0]    m_rdata,
    input  logic             h_wr,
    input  logic [1:0]       h_addr,
    input  logic [HW-1:0]    h_wdata,
    output logic [HW-1:0]    h_rdata,
    output logic             irq
);
    logic             ack, clr_cerr, wr_data;
    logic [1:0]       ack_err;
    logic             busy, cerr, rdv;
    logic [CMD_W-1:0] cmd;
    logic [AW-1:0]    addr;
    logic [HW-1:0]    data;
    logic [1:0]       err;

    eeh_hostdec i_dec (
        .h_wr       (h_wr),
        .h_addr     (h_addr),
        .cmd_field  (h_wdata[CMD_W-1:0]),
        .cerr_field (h_wdata[CERR_BIT]),
        .err_field  (h_wdata[ERR_LO+1:ERR_LO]),
        .busy_i     (busy),
        .cmd_i      (cmd),
        .ack_o      (ack),
        .ack_err_o  (ack_err),
        .clr_cerr_o (clr_cerr),
        .wr_data_o  (wr_data)
    );

    eeh_core #(.AW(AW)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_cmd_valid (m_cmd_valid),
        .m_cmd       (m_cmd),
        .m_addr      (m_addr),
        .m_wdata     (m_wdata),
        .ack_i       (ack),
        .ack_err_i   (ack_err),
        .clr_cerr_i  (clr_cerr),
        .wr_data_i   (wr_data),
        .h_wdata_i   (h_wdata),
        .busy_o      (busy),
        .cerr_o      (cerr),
        .cmd_o       (cmd),
        .addr_o      (addr),
        .data_o      (data),
        .err_o       (err),
        .rdv_o       (rdv)
    );

    eeh_rdmux #(.AW(AW)) i_rdmux (
        .h_addr  (h_addr),
        .busy_i  (busy),
        .cerr_i  (cerr),
        .err_i   (err),
        .cmd_i   (cmd),
        .addr_i  (addr),
        .data_i  (data),
        .h_rdata (h_rdata)
    );

    assign m_busy        = busy;
    assign irq           = busy;
    assign m_cmd_err     = cerr;
    assign m_ack_err     = err;
    assign m_rdata_valid = rdv;
    assign m_rdata       = data;
endmodule

// File: tb/test_eeprom_emu_handshake.sv
module test_eeprom_emu_handshake;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_cmd_valid = 1'b0;
    logic [2:0]    m_cmd = '0;
    logic [AW-1:0] m_addr = '0;
    logic [15:0]   m_wdata = '0;
    logic          m_busy, m_cmd_err, m_rdata_valid, irq;
    logic [1:0]    m_ack_err;
    logic [15:0]   m_rdata, h_rdata;
    logic          h_wr = 1'b0;
    logic [1:0]    h_addr = '0;
    logic [15:0]   h_wdata = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eeprom_emu_handshake #(.AW(AW)) i_eeprom_emu_handshake (
        .clk(clk), .rst_n(rst_n),
        .m_cmd_valid(m_cmd_valid), .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_busy(m_busy), .m_cmd_err(m_cmd_err), .m_ack_err(m_ack_err),
        .m_rdata_valid(m_rdata_valid), .m_rdata(m_rdata),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        m_cmd_valid = 1'b1; m_cmd = c; m_addr = a; m_wdata = d;
        @(negedge clk);
        m_cmd_valid = 1'b0; m_cmd = '0;
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [15:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    initial begin
        logic [15:0] rd;
        logic [15:0] exp_data;
        logic [1:0]  exp_err;
        logic [AW-1:0] addrs [3];
        addrs[0] = '0; addrs[1] = 12'h5A5; addrs[2] = '1;
        exp_data = '0; exp_err = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        hread(2'd0, rd);
        check("R1 ctrl word", rd, 32'h0);
        check("R1 busy", m_busy, 0);
        check("R1 irq", irq, 0);
        check("R1 cmd_err", m_cmd_err, 0);
        check("R1 rdata_valid", m_rdata_valid, 0);
        check("R1 ack_err", m_ack_err, 0);

        // R12 ctrl write while idle
        hwrite(2'd0, 16'h3001);
        check("R12 busy after idle write", m_busy, 0);
        check("R12 irq after idle write", irq, 0);

        for (int c = 1; c < 8; c++) begin
            for (int ai = 0; ai < 3; ai++) begin
                logic [15:0] wd;
                logic [1:0]  ev;
                wd = 16'(c * 16'h1357 + ai * 16'h0101);
                ev = 2'((c + ai) & 3);
                // R11 code 0 while idle
                issue(3'd0, addrs[ai] ^ 12'hFFF, 16'hDEAD);
                check("R11 code0 idle busy", m_busy, 0);
                issue(3'(c), addrs[ai], wd);
                if (c == 2) exp_data = wd;
                check("R2 busy set", m_busy, 1);
                check("R2 irq set", irq, 1);
                hread(2'd0, rd);
                check("R2 busy bit15", rd[15], 1);
                check("R3 cmd field", rd[2:0], c);
                hread(2'd1, rd);
                check("R3 address", rd, 32'(addrs[ai]));
                hread(2'd2, rd);
                check("R4 data word", rd, exp_data);
                // R8 refused command
                issue(3'(c ^ 1) == 0 ? 3'd3 : 3'(c ^ 1), addrs[ai] ^ 12'h0F0, ~wd);
                check("R8 cmd_err", m_cmd_err, 1);
                hread(2'd0, rd);
                check("R8 cmd_err bit14", rd[14], 1);
                check("R8 cmd unchanged", rd[2:0], c);
                hread(2'd1, rd);
                check("R8 addr unchanged", rd, 32'(addrs[ai]));
                hread(2'd2, rd);
                check("R8 data unchanged", rd, exp_data);
                // R11 code 0 while busy: no error
                hwrite(2'd0, 16'h4000 | 16'(3'(c + 1) == 0 ? 3'd1 : 3'(c + 1)));
                check("R9 cmd_err cleared", m_cmd_err, 0);
                check("R7 busy after clear write", m_busy, 1);
                issue(3'd0, '0, 16'h0);
                check("R11 code0 busy no error", m_cmd_err, 0);
                check("R11 code0 busy stays", m_busy, 1);
                // R7 all wrong codes
                for (int w = 0; w < 8; w++) begin
                    if (w != c) begin
                        hwrite(2'd0, 16'h3000 | 16'(w));
                        check("R7 busy held", m_busy, 1);
                        check("R7 irq held", irq, 1);
                        check("R7 ack_err held", m_ack_err, exp_err);
                    end
                end
                if (c == 1) begin
                    exp_data = ~wd ^ 16'h00F0;
                    hwrite(2'd2, exp_data);
                    hread(2'd2, rd);
                    check("R5 host data write", rd, exp_data);
                end
                hwrite(2'd0, (16'(ev) << 12) | 16'(c));
                exp_err = ev;
                check("R6 busy clear", m_busy, 0);
                check("R6 irq clear", irq, 0);
                check("R6 ack_err", m_ack_err, ev);
                check("R10 strobe", m_rdata_valid, (c == 1) ? 1 : 0);
                if (c == 1) check("R10 rdata", m_rdata, exp_data);
                hread(2'd0, rd);
                check("R6 err bits", rd[13:12], ev);
                @(negedge clk);
                check("R10 strobe one cycle", m_rdata_valid, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule